// File: doc/BRIEF.md
# External Bus Release Arbiter

This block lets an outside bus master borrow a processor's external bus. The outside master asks for the bus by pulling an active-low request line low. The block first passes that line through a synchronizer. Any external access cycle already running is allowed to finish. The control strobes are then parked at their inactive high level for one state. After that, the block answers with an active-low acknowledge and drops the output enables, so that address, data and strobe pads float.

While the bus is lent out, the block keeps watching the request line. When the request returns high, the acknowledge goes high again. The block then spends one reclaim state driving the strobes inactive, and after that internal accesses resume. For as long as the bus is not owned, internal masters are stalled through a hold output. If an internal access or a refresh becomes pending while the bus is released, and the request-out enable bit is set, an active-low request-out pin tells the outside master that the bus is wanted back. That pin is retimed on the falling clock edge, so it clears one and a half states after the acknowledge rises.

All pins are plain level control signals, and no data stream passes through the block.

Top module: `ext_bus_release`

## Requirements
- R1: The request input acts only after a two-stage synchronizer. A change on `bus_req_n` made between edges becomes visible in the state on the third rising edge after it.
- R2: After reset, `bus_ack_n`=1, `drive_en`=1, `strobe_idle`=0, `hold_int`=0 and `req_out_n`=1.
- R3: While a release is pending and `cycle_busy`=1, the bus is not released and the strobes are not forced. Once `cycle_busy`=0 in the waiting state, `strobe_idle`=1 for that state and the release follows on the next edge.
- R4: The release never happens in the same state in which the request is first seen. During release, `bus_ack_n`=0, `drive_en`=0 and `hold_int`=1. In the waiting state, `hold_int`=1 already.
- R5: If the synchronized request is withdrawn while the block is still waiting, the block returns to owning the bus and `bus_ack_n` never goes low.
- R6: When a high request is sampled during release, the block spends exactly one reclaim state, with `bus_ack_n`=1, `drive_en`=1, `strobe_idle`=1 and `hold_int`=1. It then returns to owning the bus with `hold_int`=0.
- R7: During release with `reqout_en`=1, a pending `int_access_req` or `refresh_req` drives `req_out_n` low half a state after the next rising edge.
- R8: Once `req_out_n` is low, it returns high 1.5 states after the rising edge of `bus_ack_n`.
- R9: With `reqout_en`=0, `req_out_n` stays 1 whatever the internal requests do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; rising edge samples the request |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_n | input | 1 | Asynchronous active-low bus request from the outside master |
| cycle_busy | input | 1 | High while an external access cycle is in progress |
| int_access_req | input | 1 | An internal master wants an external access |
| refresh_req | input | 1 | The refresh controller wants a refresh cycle |
| reqout_en | input | 1 | Enable bit for the request-out pin |
| bus_ack_n | output | 1 | Active-low bus grant to the outside master |
| req_out_n | output | 1 | Active-low bus-wanted-back indication |
| drive_en | output | 1 | Output enable for the address, data and strobe pads |
| strobe_idle | output | 1 | Forces the read, write and address strobes to their inactive high level |
| hold_int | output | 1 | Stalls internal masters while the bus is not owned |

## Verification
On every cycle, the embedded assertions check these rules:
- a release never follows directly from the owned state;
- a busy cycle keeps the block waiting;
- reclaim lasts exactly one state;
- a low acknowledge always comes with the pads floated and internal masters held;
- the request-out stage sets only after a released cycle with the enable bit on.

Only the bench scenarios can show the exact latencies. These are the three-edge synchronizer delay, the one-state strobe parking on both sides of a release, an abandoned release that never acknowledges, and the half-state offset of the request-out pin.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  typedef enum logic [1:0] {
    ST_OWNED    = 2'd0,
    ST_WAIT     = 2'd1,
    ST_RELEASED = 2'd2,
    ST_RECLAIM  = 2'd3
  } ebr_state_e;
endpackage

// File: rtl/ebr_sync.sv
module ebr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ebr_fsm.sv
module ebr_fsm
  import ebr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_active,
  input  logic       cycle_busy,
  output ebr_state_e state_o,
  output logic       ack_n_o,
  output logic       drive_en_o,
  output logic       strobe_idle_o,
  output logic       hold_o
);
  ebr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OWNED:    if (req_active) state_d = ST_WAIT;
      ST_WAIT: begin
        if (!req_active)      state_d = ST_OWNED;
        else if (!cycle_busy) state_d = ST_RELEASED;
      end
      ST_RELEASED: if (!req_active) state_d = ST_RECLAIM;
      ST_RECLAIM:  state_d = ST_OWNED;
      default:     state_d = ST_OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OWNED;
    else        state_q <= state_d;
  end

  assign state_o       = state_q;
  assign ack_n_o       = (state_q != ST_RELEASED);
  assign drive_en_o    = (state_q != ST_RELEASED);
  assign hold_o        = (state_q != ST_OWNED);
  assign strobe_idle_o = (state_q == ST_RECLAIM) ||
                         (state_q == ST_WAIT && !cycle_busy);

  // R3
  wait_busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && cycle_busy && req_active) |=> (state_q == ST_WAIT));

  // R4
  no_direct_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OWNED) |=> (state_q != ST_RELEASED));

  // R6
  reclaim_one_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECLAIM) |=> (state_q == ST_OWNED));
endmodule

// File: rtl/ebr_reqout.sv
module ebr_reqout (
  input  logic clk,
  input  logic rst_n,
  input  logic released_i,
  input  logic en_i,
  input  logic pending_i,
  output logic req_out_n_o
);
  logic ro_pos_q;
  logic ro_neg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ro_pos_q <= 1'b0;
    else        ro_pos_q <= released_i && en_i && pending_i;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ro_neg_q <= 1'b0;
    else        ro_neg_q <= ro_pos_q;
  end

  assign req_out_n_o = !ro_neg_q;

  // R9
  ro_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_pos_q |-> $past(en_i));

  // R7
  ro_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_pos_q |-> $past(released_i));
endmodule

// File: rtl/ext_bus_release.sv
module ext_bus_release
  import ebr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_n,
  input  logic cycle_busy,
  input  logic int_access_req,
  input  logic refresh_req,
  input  logic reqout_en,
  output logic bus_ack_n,
  output logic req_out_n,
  output logic drive_en,
  output logic strobe_idle,
  output logic hold_int
);
  logic       req_n_sync;
  ebr_state_e state;

  ebr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (bus_req_n),
    .q_o   (req_n_sync)
  );

  ebr_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_active    (!req_n_sync),
    .cycle_busy    (cycle_busy),
    .state_o       (state),
    .ack_n_o       (bus_ack_n),
    .drive_en_o    (drive_en),
    .strobe_idle_o (strobe_idle),
    .hold_o        (hold_int)
  );

  ebr_reqout u_reqout (
    .clk         (clk),
    .rst_n       (rst_n),
    .released_i  (state == ST_RELEASED),
    .en_i        (reqout_en),
    .pending_i   (int_access_req || refresh_req),
    .req_out_n_o (req_out_n)
  );

  // R4
  release_floats_and_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n |-> (hold_int && !drive_en));
endmodule

// File: tb/ext_bus_release_bench.sv
module ext_bus_release_bench;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req_n = 1'b1;
  logic cycle_busy = 1'b0;
  logic int_access_req = 1'b0;
  logic refresh_req = 1'b0;
  logic reqout_en = 1'b0;
  logic bus_ack_n, req_out_n, drive_en, strobe_idle, hold_int;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    int         at;
    string      tag;
    logic [4:0] exp;
  } exp_t;
  exp_t sb_q[$];

  ext_bus_release u_ext_bus_release (
    .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .cycle_busy(cycle_busy),
    .int_access_req(int_access_req), .refresh_req(refresh_req),
    .reqout_en(reqout_en), .bus_ack_n(bus_ack_n), .req_out_n(req_out_n),
    .drive_en(drive_en), .strobe_idle(strobe_idle), .hold_int(hold_int)
  );

  always #(P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // vector order: {bus_ack_n, drive_en, strobe_idle, hold_int, req_out_n}
  task automatic expect_at(input int off, input string tag, input logic [4:0] v);
    exp_t e;
    e.at = cyc + off; e.tag = tag; e.exp = v;
    sb_q.push_back(e);
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #(P/4);
    end
  endtask

  // monitor: samples after the falling edge, well away from the rising edge
  always @(posedge clk) begin
    #(P*3/4);
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      exp_t e;
      logic [4:0] act;
      e = sb_q.pop_front();
      act = {bus_ack_n, drive_en, strobe_idle, hold_int, req_out_n};
      n_run++;
      if (act !== e.exp || e.at != cyc) begin
        n_fail++;
        $display("FAIL %s cycle %0d: actual %b expected %b", e.tag, cyc, act, e.exp);
      end
    end
  end

  initial begin
    #(P*5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    // R2 reset state
    expect_at(0, "R2", 5'b11001);
    step(2);

    // R1, R4, R3, R6: plain release with idle bus
    bus_req_n = 1'b0;
    expect_at(2, "R1", 5'b11001);
    expect_at(3, "R3", 5'b11111);
    expect_at(4, "R4", 5'b00011);
    step(6);
    bus_req_n = 1'b1;
    expect_at(2, "R1", 5'b00011);
    expect_at(3, "R6", 5'b11111);
    expect_at(4, "R6", 5'b11001);
    step(6);

    // R3: a busy cycle delays the release
    cycle_busy = 1'b1;
    bus_req_n = 1'b0;
    expect_at(3, "R3", 5'b11011);
    expect_at(4, "R3", 5'b11011);
    step(5);
    cycle_busy = 1'b0;
    expect_at(0, "R3", 5'b11111);
    expect_at(1, "R4", 5'b00011);
    step(3);
    bus_req_n = 1'b1;
    step(6);

    // R5: request withdrawn while waiting
    cycle_busy = 1'b1;
    bus_req_n = 1'b0;
    step(3);
    bus_req_n = 1'b1;
    expect_at(0, "R5", 5'b11011);
    expect_at(2, "R5", 5'b11011);
    expect_at(3, "R5", 5'b11001);
    step(5);
    cycle_busy = 1'b0;
    step(2);

    // R7, R8: internal access pending during release
    reqout_en = 1'b1;
    bus_req_n = 1'b0;
    step(5);
    expect_at(0, "R7", 5'b00011);
    int_access_req = 1'b1;
    expect_at(1, "R7", 5'b00010);
    step(3);
    bus_req_n = 1'b1;
    expect_at(2, "R8", 5'b00010);
    expect_at(3, "R8", 5'b11110);
    expect_at(4, "R8", 5'b11001);
    step(6);
    int_access_req = 1'b0;
    step(2);

    // R7: refresh also raises the request-out
    bus_req_n = 1'b0;
    step(5);
    refresh_req = 1'b1;
    expect_at(1, "R7", 5'b00010);
    step(2);
    refresh_req = 1'b0;
    expect_at(1, "R7", 5'b00011);
    step(2);
    bus_req_n = 1'b1;
    step(6);

    // R9: enable off keeps request-out high
    reqout_en = 1'b0;
    bus_req_n = 1'b0;
    step(5);
    refresh_req = 1'b1;
    int_access_req = 1'b1;
    expect_at(1, "R9", 5'b00011);
    expect_at(3, "R9", 5'b00011);
    step(4);
    bus_req_n = 1'b1;
    expect_at(3, "R9", 5'b11111);
    step(6);
    refresh_req = 1'b0;
    int_access_req = 1'b0;

    step(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule